// File: doc/BRIEF.md
# Register-Overlay Memory Read Path

This block stands between the processor's memory access signals and the external memory port. The lowest seven word addresses are not memory at all: they are held in fast flip-flop registers inside the block, and register 0 is the accumulator. A read at one of these addresses returns the register contents and never touches memory. A read at any higher address is passed to the external memory, and the returned word is checked for odd parity before its parity bit is removed.

Writes follow the same split. A write to a low address updates the register at the clock edge and is kept off the memory port. A write to a higher address is forwarded to memory together with a freshly generated parity bit. After reset every overlay register holds all ones. An absent memory that reads back as all zeros therefore shows up at once as a parity error, while reads of the accumulator and the other overlay registers stay clean.

Top module: `ovl_read_path`

## Requirements
- R1: After reset every overlay register, including the accumulator on `acc`, holds all ones (0x7FFF), and `rd_valid` and `par_err` are low.
- R2: Addresses 0 to 6 are overlay addresses and 7 upward are external. `mem_re` is high in the same cycle exactly when `rd_en` is high with an external address.
- R3: A read of overlay address a returns register a on `rd_data`, with `rd_valid` high, one clock after `rd_en` is sampled.
- R4: Address 0 is the accumulator: a read of address 0 returns the value on `acc`, and a write to address 0 changes `acc` at the next clock edge.
- R5: An external read returns `mem_data` (15 bits, parity stripped) on `rd_data` one clock after `rd_en`, with `rd_valid` high.
- R6: One clock after an external read, `par_err` is high exactly when the 16 bits {`mem_par`, `mem_data`} hold an even number of ones. An all-zero word with a zero parity bit is therefore an error.
- R7: An overlay read never raises `par_err`, whatever `mem_data` and `mem_par` carry.
- R8: A write to an overlay address updates that register at the clock edge and keeps `mem_we` low.
- R9: A write to an external address drives `mem_we` high in the same cycle, with `mem_wdata` equal to `wr_data` and `mem_wpar` chosen so that the 16 bits hold an odd number of ones. No overlay register changes.
- R10: When a read and a write hit the same overlay register in one cycle, the read returns the value held before the write, and the next read returns the new value.
- R11: In a cycle with `rd_en` low, `rd_valid` and `par_err` are low one clock later and `rd_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe from the processor |
| rd_addr | input | 12 | Read word address |
| wr_en | input | 1 | Write strobe from the processor |
| wr_addr | input | 12 | Write word address |
| wr_data | input | 15 | Write data |
| mem_data | input | 15 | Data word returned by external memory |
| mem_par | input | 1 | Parity bit returned by external memory |
| mem_re | output | 1 | External read request |
| mem_we | output | 1 | External write request |
| mem_wdata | output | 15 | Data word sent to external memory |
| mem_wpar | output | 1 | Odd-parity bit sent with the write word |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 15 | Read result, parity removed |
| par_err | output | 1 | Parity error on the reported external read |
| acc | output | 15 | Current accumulator (register 0) |

## Verification
A read and a write can fall on the same overlay register in one cycle. The bench provokes this on every overlay address by driving both strobes at the same address with a new value. It expects the old contents on the first result and the new contents on a read in the following cycle. The parity check is swept over all 65,536 combinations of data word and parity bit while the read addresses walk the external range. Each error flag is compared with a parity computed in the bench.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned DATA_W   = 15;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NUM_REGS = 7;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_MEM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile #(
  parameter int unsigned DATA_W   = 15,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] reg0
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic [NUM_REGS-1:0] sel_en;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign sel_en[g] = we && (widx == IDX_W'(g));

    always_comb begin
      regs_d[g] = regs_q[g];
      if (sel_en[g]) regs_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '1;
      else if (sel_en[g]) regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx == IDX_W'(i)) rdata = regs_q[i];
    end
  end

  assign reg0 = regs_q[0];
endmodule

// File: rtl/ovl_parity.sv
module ovl_parity #(
  parameter int unsigned DATA_W = 15
) (
  input  logic [DATA_W-1:0] chk_data,
  input  logic              chk_par,
  output logic              chk_odd,
  input  logic [DATA_W-1:0] gen_data,
  output logic              gen_par
);
  assign chk_odd = ^{chk_par, chk_data};
  assign gen_par = ~(^gen_data);
endmodule

// File: rtl/ovl_read_path.sv
module ovl_read_path
  import ovl_pkg::*;
#(
  parameter int unsigned P_DATA_W   = DATA_W,
  parameter int unsigned P_ADDR_W   = ADDR_W,
  parameter int unsigned P_NUM_REGS = NUM_REGS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [P_ADDR_W-1:0]   rd_addr,
  input  logic                  wr_en,
  input  logic [P_ADDR_W-1:0]   wr_addr,
  input  logic [P_DATA_W-1:0]   wr_data,
  input  logic [P_DATA_W-1:0]   mem_data,
  input  logic                  mem_par,
  output logic                  mem_re,
  output logic                  mem_we,
  output logic [P_DATA_W-1:0]   mem_wdata,
  output logic                  mem_wpar,
  output logic                  rd_valid,
  output logic [P_DATA_W-1:0]   rd_data,
  output logic                  par_err,
  output logic [P_DATA_W-1:0]   acc
);
  localparam int unsigned IDX_W = (P_NUM_REGS > 1) ? $clog2(P_NUM_REGS) : 1;
  localparam logic [P_ADDR_W-1:0] REG_LIMIT = P_ADDR_W'(P_NUM_REGS);

  logic rst_n_sync;

  ovl_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  // address decode
  logic rd_is_reg;
  logic wr_is_reg;
  rd_src_e rd_src;

  assign rd_is_reg = rd_addr < REG_LIMIT;
  assign wr_is_reg = wr_addr < REG_LIMIT;

  always_comb begin
    rd_src = SRC_NONE;
    if (rd_en) rd_src = rd_is_reg ? SRC_REG : SRC_MEM;
  end

  // overlay registers
  logic [P_DATA_W-1:0] reg_rdata;

  ovl_regfile #(
    .DATA_W  (P_DATA_W),
    .NUM_REGS(P_NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .we   (wr_en && wr_is_reg),
    .widx (wr_addr[IDX_W-1:0]),
    .wdata(wr_data),
    .ridx (rd_addr[IDX_W-1:0]),
    .rdata(reg_rdata),
    .reg0 (acc)
  );

  // parity check and generation
  logic mem_odd;

  ovl_parity #(
    .DATA_W(P_DATA_W)
  ) u_par (
    .chk_data(mem_data),
    .chk_par (mem_par),
    .chk_odd (mem_odd),
    .gen_data(wr_data),
    .gen_par (mem_wpar)
  );

  // external port
  assign mem_re    = rd_src == SRC_MEM;
  assign mem_we    = wr_en && !wr_is_reg;
  assign mem_wdata = wr_data;

  // output stage: next state
  logic                valid_d;
  logic                err_d;
  logic [P_DATA_W-1:0] data_d;
  logic                data_en;

  always_comb begin
    valid_d = 1'b0;
    err_d   = 1'b0;
    data_d  = rd_data;
    data_en = 1'b0;
    unique case (rd_src)
      SRC_REG: begin
        valid_d = 1'b1;
        data_d  = reg_rdata;
        data_en = 1'b1;
      end
      SRC_MEM: begin
        valid_d = 1'b1;
        err_d   = !mem_odd;
        data_d  = mem_data;
        data_en = 1'b1;
      end
      default: ;
    endcase
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rd_valid <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rd_valid <= valid_d;
      par_err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rd_data <= '0;
    else if (data_en) rd_data <= data_d;
  end
endmodule

// File: rtl/ovl_read_path_chk.sv
module ovl_read_path_chk #(
  parameter int unsigned P_DATA_W   = 15,
  parameter int unsigned P_ADDR_W   = 12,
  parameter int unsigned P_NUM_REGS = 7
) (
  input logic                clk,
  input logic                rst_n_sync,
  input logic                rd_en,
  input logic [P_ADDR_W-1:0] rd_addr,
  input logic                wr_en,
  input logic [P_ADDR_W-1:0] wr_addr,
  input logic                mem_re,
  input logic                mem_we,
  input logic [P_DATA_W-1:0] mem_wdata,
  input logic                mem_wpar,
  input logic                rd_valid,
  input logic [P_DATA_W-1:0] rd_data,
  input logic                par_err,
  input logic [P_DATA_W-1:0] acc
);
  localparam logic [P_ADDR_W-1:0] LIM = P_ADDR_W'(P_NUM_REGS);

  // R2
  mem_re_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_re |-> (rd_en && rd_addr >= LIM));

  // R4
  acc_read_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && rd_addr == '0 && !(wr_en && wr_addr == '0)) |=> (rd_data == acc));

  // R6
  err_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    par_err |-> rd_valid);

  // R7
  reg_read_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_en && rd_addr < LIM) |=> !par_err);

  // R8
  reg_write_local_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && wr_addr < LIM) |-> !mem_we);

  // R9
  write_parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_we |-> (^{mem_wpar, mem_wdata}));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rd_en |=> (!rd_valid && !par_err && $stable(rd_data)));
endmodule

bind ovl_read_path ovl_read_path_chk #(
  .P_DATA_W  (P_DATA_W),
  .P_ADDR_W  (P_ADDR_W),
  .P_NUM_REGS(P_NUM_REGS)
) u_chk (
  .clk       (clk),
  .rst_n_sync(rst_n_sync),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_wpar  (mem_wpar),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .par_err   (par_err),
  .acc       (acc)
);

// File: tb/ovl_read_path_bench.sv
module ovl_read_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 15;
  localparam int AW = 12;
  localparam int NR = 7;
  localparam logic [DW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_en, wr_en, mem_par;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data, mem_data;
  logic          mem_re, mem_we, mem_wpar, rd_valid, par_err;
  logic [DW-1:0] mem_wdata, rd_data, acc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] shadow [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_read_path u_ovl_read_path (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_data(mem_data), .mem_par(mem_par), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
    .rd_valid(rd_valid), .rd_data(rd_data), .par_err(par_err), .acc(acc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  // read every overlay register and compare with the shadow copy
  task automatic read_regs(input string req);
    for (int a = 0; a < NR; a++) begin
      idle();
      rd_en = 1'b1; rd_addr = AW'(a);
      mem_data = '0; mem_par = 1'b0;
      #1 chk({req, " R2 mem_re low"}, 32'(mem_re), 0);
      step();
      chk({req, " R3 data"}, 32'(rd_data), 32'(shadow[a]));
      chk({req, " R3 valid"}, 32'(rd_valid), 1);
      chk({req, " R7 no err"}, 32'(par_err), 0);
    end
    idle();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    rd_addr = '0; wr_addr = '0; wr_data = '0; mem_data = '0; mem_par = 1'b0;
    for (int i = 0; i < NR; i++) shadow[i] = ONES;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 acc", 32'(acc), 32'(ONES));
    chk("R1 valid", 32'(rd_valid), 0);
    chk("R1 err", 32'(par_err), 0);
    read_regs("R1 reset");

    // R4 address 0 equals acc
    rd_en = 1'b1; rd_addr = '0; step(); idle();
    chk("R4 read0", 32'(rd_data), 32'(acc));

    // R8 overlay writes
    for (int a = 0; a < NR; a++) begin
      logic [DW-1:0] v;
      v = DW'((a * 32'h1357) ^ 32'h2A5C);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
      #1 chk("R8 mem_we low", 32'(mem_we), 0);
      step(); idle();
      shadow[a] = v;
      if (a == 0) chk("R4 acc write", 32'(acc), 32'(v));
    end
    read_regs("R8 readback");

    // R10 same-cycle read and write
    for (int a = 0; a < NR; a++) begin
      logic [DW-1:0] v;
      v = ~shadow[a];
      rd_en = 1'b1; rd_addr = AW'(a);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
      step(); idle();
      chk("R10 old value", 32'(rd_data), 32'(shadow[a]));
      shadow[a] = v;
      rd_en = 1'b1; rd_addr = AW'(a);
      step(); idle();
      chk("R10 new value", 32'(rd_data), 32'(v));
    end

    // R9 external writes
    for (int k = 0; k < 64; k++) begin
      logic [DW-1:0] v;
      v = DW'(k * 32'h0BAD + k);
      wr_en = 1'b1; wr_addr = AW'(NR + k * 61); wr_data = v;
      #1;
      chk("R9 mem_we", 32'(mem_we), 1);
      chk("R9 wdata", 32'(mem_wdata), 32'(v));
      chk("R9 odd parity", 32'($countones({mem_wpar, mem_wdata}) % 2), 1);
      step(); idle();
    end
    read_regs("R9 regs unchanged");

    // R5 R6 R2 exhaustive external read sweep
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] w;
      w = 16'(v);
      rd_en = 1'b1; rd_addr = AW'(NR + (v % ((1 << AW) - NR)));
      mem_data = w[DW-1:0]; mem_par = w[15];
      #1 chk("R2 mem_re", 32'(mem_re), 1);
      step();
      chk("R5 data", 32'(rd_data), 32'(w[DW-1:0]));
      chk("R5 valid", 32'(rd_valid), 1);
      chk("R6 err", 32'(par_err), 32'(($countones(w) % 2) == 0));
    end

    // R6 all-zero word
    rd_en = 1'b1; rd_addr = AW'(NR); mem_data = '0; mem_par = 1'b0;
    step();
    chk("R6 zero word err", 32'(par_err), 1);

    // R11 idle holds data
    begin
      logic [DW-1:0] held;
      held = rd_data;
      idle(); mem_data = 15'h1234; mem_par = 1'b0;
      step();
      chk("R11 valid low", 32'(rd_valid), 0);
      chk("R11 err low", 32'(par_err), 0);
      chk("R11 data held", 32'(rd_data), 32'(held));
    end

    // R7 overlay read with bad memory parity present
    rd_en = 1'b1; rd_addr = AW'(NR - 1); mem_data = '0; mem_par = 1'b0;
    step(); idle();
    chk("R7 last reg no err", 32'(par_err), 0);
    chk("R3 last reg data", 32'(rd_data), 32'(shadow[NR-1]));

    done = 1'b1;
    summary();
  end
endmodule